// File: doc/BRIEF.md
# Ring Beamformer Node with Single-Baseline Correlator

This block is one identical stage of a ring of beamforming nodes. Each stage takes four complex sample streams, multiplies each by its own programmable complex weight, and adds the four weighted samples to the partial beam sum that arrives from the upstream stage. The saturated result goes to the downstream stage one cycle later. A tap selector picks either one weighted input or the new partial sum, and sends it to the channelizer that sits outside the block. Because the stages are chained, a tap anywhere in the ring sees either a single input or the running sum of every input upstream of it.

Channelized samples come back on two valid-qualified inputs. The first is the local stream. The second is the stream received from the upstream stage, which this stage also forwards downstream after one register. Whenever both are valid in the same cycle, the node multiplies the local sample by the complex conjugate of the upstream sample. It adds the product into a saturating 32-bit complex integrator.

The integrator is double-buffered. After a programmable number of products, the finished total moves to the readout bank, the running bank restarts from zero, and a ready flag rises. The flag stays high until the host acknowledges it through a small register port. The same port sets the weights, the tap selection and the integration length.

Top module: `bf_ring_node`

## Requirements
- R1: When `smp_valid` and `bin_valid` are both high at a clock edge, then after that edge `bout_valid` is high and `bout_re`/`bout_im` carry the upstream sum plus the four weighted samples, each weight product being (xr*wr - xi*wi) + j(xr*wi + xi*wr). In any other cycle `bout_valid` is low and the beam data holds its last value.
- R2: `tap_valid` always equals `bout_valid`. For a select value k of 0 to 3, the tap data is weighted input k alone, saturated to 24 bits. For a select value of 4 to 7, the tap data equals the beam output.
- R3: Register map (4-bit address, 32-bit data). Addresses 0 to 3 hold weight k, with the real part at bits 11:0 and the imaginary part at bits 23:12, both signed 12-bit. Address 4 is the tap select, bits 2:0. Address 5 is the integration length, 32 bits. Address 6 is the dump real part and address 7 the dump imaginary part, both signed 32-bit and read-only. Address 8 is status, with bit 0 the ready flag. Writes take effect at the clock edge. Reads are combinational and return 0 for unmapped addresses. After reset the weights are 0, the select is 0 and the length is 4.
- R4: Each beam output component saturates to the signed 24-bit range instead of wrapping.
- R5: A correlation product is formed only in cycles where `loc_valid` and `prv_valid` are both high. The product is local times the conjugate of upstream: (lr*pr + li*pi) + j(li*pr - lr*pi).
- R6: Each integrator component saturates to the signed 32-bit range at every addition.
- R7: An integration period ends on the product that brings the product count to the length register, with a length of 0 treated as 1. On that edge the dump registers take the final total including that product, the running total restarts at 0, and the ready flag is set.
- R8: The ready flag stays high until a write of 1 to bit 0 of address 8 clears it. If a period ends in the same cycle as that write, the flag stays set.
- R9: `nxt_valid`, `nxt_re` and `nxt_im` repeat `prv_valid`, `prv_re` and `prv_im` with exactly one cycle of latency.
- R10: While `rst_n` is low, every valid output is low, all output data is zero, the dump registers read zero and the ready flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | The four input samples are valid |
| smp_re | input | 32 | Real parts of four 8-bit signed samples, input k at bits 8k+7:8k |
| smp_im | input | 32 | Imaginary parts, same packing |
| bin_valid | input | 1 | Upstream beam sum valid |
| bin_re | input | 24 | Upstream beam sum, real |
| bin_im | input | 24 | Upstream beam sum, imaginary |
| bout_valid | output | 1 | Beam sum to downstream valid |
| bout_re | output | 24 | Beam sum to downstream, real |
| bout_im | output | 24 | Beam sum to downstream, imaginary |
| tap_valid | output | 1 | Tap stream valid |
| tap_re | output | 24 | Tap stream, real |
| tap_im | output | 24 | Tap stream, imaginary |
| loc_valid | input | 1 | Local channelized sample valid |
| loc_re | input | 16 | Local channelized sample, real |
| loc_im | input | 16 | Local channelized sample, imaginary |
| prv_valid | input | 1 | Upstream channelized sample valid |
| prv_re | input | 16 | Upstream channelized sample, real |
| prv_im | input | 16 | Upstream channelized sample, imaginary |
| nxt_valid | output | 1 | Forwarded channelized sample valid |
| nxt_re | output | 16 | Forwarded channelized sample, real |
| nxt_im | output | 16 | Forwarded channelized sample, imaginary |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench drives full-scale samples and weights so that the beam sum saturates. A design that wrapped would flip the sign of the downstream sum. It also drives extreme correlator samples whose single product already exceeds 32 bits, which exposes an integrator that truncates instead of clipping. Integration lengths of 0, 1 and several samples are mixed with independent local and upstream valids. This catches an off-by-one period end, a dump that misses its last product, a bank that is not cleared, and products taken when only one side is valid. Acknowledge writes land on arbitrary cycles, some of them on a swap, so a flag that ignores the acknowledge, or lets it beat a new dump, shows up on the status read.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef logic signed [63:0] wide_t;

  typedef struct packed {
    wide_t re;
    wide_t im;
  } cplx_t;

  // clip a wide signed value into a signed w-bit range
  function automatic wide_t sat_s(input wide_t v, input int w);
    wide_t hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // a * b
  function automatic cplx_t cmul(input wide_t ar, input wide_t ai,
                                 input wide_t br, input wide_t bi);
    cplx_t r;
    r.re = ar * br - ai * bi;
    r.im = ar * bi + ai * br;
    return r;
  endfunction

  // a * conj(b)
  function automatic cplx_t cmul_conj(input wide_t ar, input wide_t ai,
                                      input wide_t br, input wide_t bi);
    cplx_t r;
    r.re = ar * br + ai * bi;
    r.im = ai * br - ar * bi;
    return r;
  endfunction
endpackage

// File: rtl/bf_regs.sv
module bf_regs #(
  parameter int NIN     = 4,
  parameter int WW      = 12,
  parameter int SLW     = 3,
  parameter int LW      = 32,
  parameter int AW      = 32,
  parameter int RAW     = 4,
  parameter int LEN_RST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [RAW-1:0]        reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [NIN*WW-1:0]     w_re,
  output logic [NIN*WW-1:0]     w_im,
  output logic [SLW-1:0]        tap_sel,
  output logic [LW-1:0]         int_len,
  output logic                  ack_evt,
  input  logic signed [AW-1:0]  dump_re,
  input  logic signed [AW-1:0]  dump_im,
  input  logic                  dump_ready
);
  localparam logic [RAW-1:0] A_SEL  = RAW'(NIN);
  localparam logic [RAW-1:0] A_LEN  = RAW'(NIN + 1);
  localparam logic [RAW-1:0] A_DRE  = RAW'(NIN + 2);
  localparam logic [RAW-1:0] A_DIM  = RAW'(NIN + 3);
  localparam logic [RAW-1:0] A_STAT = RAW'(NIN + 4);

  logic [WW-1:0] wre_q [NIN];
  logic [WW-1:0] wim_q [NIN];
  logic          unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata[31:2*WW];
  assign ack_evt = reg_we && (reg_addr == A_STAT) && reg_wdata[0];

  for (genvar k = 0; k < NIN; k++) begin : g_w
    assign w_re[k*WW +: WW] = wre_q[k];
    assign w_im[k*WW +: WW] = wim_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wre_q[k] <= '0;
        wim_q[k] <= '0;
      end else if (reg_we && reg_addr == RAW'(k)) begin
        wre_q[k] <= reg_wdata[WW-1:0];
        wim_q[k] <= reg_wdata[2*WW-1:WW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_sel <= '0;
      int_len <= LW'(LEN_RST);
    end else if (reg_we) begin
      if (reg_addr == A_SEL) tap_sel <= reg_wdata[SLW-1:0];
      if (reg_addr == A_LEN) int_len <= reg_wdata[LW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NIN; k++)
      if (reg_addr == RAW'(k)) reg_rdata = 32'({wim_q[k], wre_q[k]});
    if (reg_addr == A_SEL)  reg_rdata = 32'(tap_sel);
    if (reg_addr == A_LEN)  reg_rdata = 32'(int_len);
    if (reg_addr == A_DRE)  reg_rdata = 32'(dump_re);
    if (reg_addr == A_DIM)  reg_rdata = 32'(dump_im);
    if (reg_addr == A_STAT) reg_rdata = 32'(dump_ready);
  end
endmodule

// File: rtl/bf_beam_sum.sv
module bf_beam_sum
  import bf_pkg::*;
#(
  parameter int NIN = 4,
  parameter int SW  = 8,
  parameter int WW  = 12,
  parameter int BW  = 24,
  parameter int SLW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [NIN*SW-1:0]    smp_re,
  input  logic [NIN*SW-1:0]    smp_im,
  input  logic [NIN*WW-1:0]    w_re,
  input  logic [NIN*WW-1:0]    w_im,
  input  logic [SLW-1:0]       tap_sel,
  input  logic                 bin_valid,
  input  logic signed [BW-1:0] bin_re,
  input  logic signed [BW-1:0] bin_im,
  output logic                 bout_valid,
  output logic signed [BW-1:0] bout_re,
  output logic signed [BW-1:0] bout_im,
  output logic                 tap_valid,
  output logic signed [BW-1:0] tap_re,
  output logic signed [BW-1:0] tap_im
);
  wide_t wt_re [NIN];
  wide_t wt_im [NIN];
  wide_t sum_re, sum_im, pick_re, pick_im;
  cplx_t prod;
  logic  fire;

  assign fire = smp_valid & bin_valid;

  always_comb begin
    sum_re = wide_t'(bin_re);
    sum_im = wide_t'(bin_im);
    for (int k = 0; k < NIN; k++) begin
      prod = cmul($signed(smp_re[k*SW +: SW]), $signed(smp_im[k*SW +: SW]),
                  $signed(w_re[k*WW +: WW]),   $signed(w_im[k*WW +: WW]));
      wt_re[k] = prod.re;
      wt_im[k] = prod.im;
      sum_re   = sum_re + prod.re;
      sum_im   = sum_im + prod.im;
    end
    pick_re = sum_re;
    pick_im = sum_im;
    for (int k = 0; k < NIN; k++) begin
      if (tap_sel == SLW'(k)) begin
        pick_re = wt_re[k];
        pick_im = wt_im[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bout_valid <= 1'b0;
      tap_valid  <= 1'b0;
      bout_re    <= '0;
      bout_im    <= '0;
      tap_re     <= '0;
      tap_im     <= '0;
    end else begin
      bout_valid <= fire;
      tap_valid  <= fire;
      if (fire) begin
        bout_re <= BW'(sat_s(sum_re, BW));
        bout_im <= BW'(sat_s(sum_im, BW));
        tap_re  <= BW'(sat_s(pick_re, BW));
        tap_im  <= BW'(sat_s(pick_im, BW));
      end
    end
  end
endmodule

// File: rtl/bf_xcorr.sv
module bf_xcorr
  import bf_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loc_valid,
  input  logic signed [CW-1:0] loc_re,
  input  logic signed [CW-1:0] loc_im,
  input  logic                 prv_valid,
  input  logic signed [CW-1:0] prv_re,
  input  logic signed [CW-1:0] prv_im,
  input  logic [LW-1:0]        int_len,
  input  logic                 ack_evt,
  output logic signed [AW-1:0] dump_re,
  output logic signed [AW-1:0] dump_im,
  output logic signed [AW-1:0] act_re,
  output logic signed [AW-1:0] act_im,
  output logic                 dump_ready,
  output logic                 swap_evt
);
  logic signed [AW-1:0] bank_re [2];
  logic signed [AW-1:0] bank_im [2];
  logic                 act_sel;
  logic [LW-1:0]        cnt;
  logic [LW:0]          eff_len;
  logic                 prod_evt, last;
  cplx_t                prod;
  wide_t                nxt_re, nxt_im;

  assign prod_evt = loc_valid & prv_valid;
  assign eff_len  = (int_len == '0) ? (LW+1)'(1) : {1'b0, int_len};
  assign last     = ({1'b0, cnt} + (LW+1)'(1)) >= eff_len;
  assign swap_evt = prod_evt & last;

  assign act_re  = bank_re[act_sel];
  assign act_im  = bank_im[act_sel];
  assign dump_re = bank_re[~act_sel];
  assign dump_im = bank_im[~act_sel];

  always_comb begin
    prod   = cmul_conj(loc_re, loc_im, prv_re, prv_im);
    nxt_re = sat_s(wide_t'(act_re) + prod.re, AW);
    nxt_im = sat_s(wide_t'(act_im) + prod.im, AW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_re[0] <= '0;
      bank_re[1] <= '0;
      bank_im[0] <= '0;
      bank_im[1] <= '0;
      act_sel    <= 1'b0;
      cnt        <= '0;
      dump_ready <= 1'b0;
    end else begin
      if (prod_evt) begin
        bank_re[act_sel] <= AW'(nxt_re);
        bank_im[act_sel] <= AW'(nxt_im);
        if (last) begin
          bank_re[~act_sel] <= '0;
          bank_im[~act_sel] <= '0;
          act_sel           <= ~act_sel;
          cnt               <= '0;
        end else begin
          cnt <= cnt + LW'(1);
        end
      end
      if (swap_evt)     dump_ready <= 1'b1;
      else if (ack_evt) dump_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/bf_ring_node.sv
module bf_ring_node #(
  parameter int NIN     = 4,
  parameter int SW      = 8,
  parameter int WW      = 12,
  parameter int BW      = 24,
  parameter int CW      = 16,
  parameter int AW      = 32,
  parameter int LW      = 32,
  parameter int RAW     = 4,
  parameter int LEN_RST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [NIN*SW-1:0]    smp_re,
  input  logic [NIN*SW-1:0]    smp_im,
  input  logic                 bin_valid,
  input  logic signed [BW-1:0] bin_re,
  input  logic signed [BW-1:0] bin_im,
  output logic                 bout_valid,
  output logic signed [BW-1:0] bout_re,
  output logic signed [BW-1:0] bout_im,
  output logic                 tap_valid,
  output logic signed [BW-1:0] tap_re,
  output logic signed [BW-1:0] tap_im,
  input  logic                 loc_valid,
  input  logic signed [CW-1:0] loc_re,
  input  logic signed [CW-1:0] loc_im,
  input  logic                 prv_valid,
  input  logic signed [CW-1:0] prv_re,
  input  logic signed [CW-1:0] prv_im,
  output logic                 nxt_valid,
  output logic signed [CW-1:0] nxt_re,
  output logic signed [CW-1:0] nxt_im,
  input  logic                 reg_we,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  localparam int SLW = $clog2(NIN + 1);

  logic [NIN*WW-1:0]    w_re, w_im;
  logic [SLW-1:0]       tap_sel;
  logic [LW-1:0]        int_len;
  logic                 ack_evt, swap_evt, dump_ready;
  logic signed [AW-1:0] dump_re, dump_im, act_re, act_im;

  bf_regs #(.NIN(NIN), .WW(WW), .SLW(SLW), .LW(LW), .AW(AW), .RAW(RAW),
            .LEN_RST(LEN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .w_re(w_re), .w_im(w_im),
    .tap_sel(tap_sel), .int_len(int_len), .ack_evt(ack_evt),
    .dump_re(dump_re), .dump_im(dump_im), .dump_ready(dump_ready)
  );

  bf_beam_sum #(.NIN(NIN), .SW(SW), .WW(WW), .BW(BW), .SLW(SLW)) u_beam (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_re(smp_re),
    .smp_im(smp_im), .w_re(w_re), .w_im(w_im), .tap_sel(tap_sel),
    .bin_valid(bin_valid), .bin_re(bin_re), .bin_im(bin_im),
    .bout_valid(bout_valid), .bout_re(bout_re), .bout_im(bout_im),
    .tap_valid(tap_valid), .tap_re(tap_re), .tap_im(tap_im)
  );

  bf_xcorr #(.CW(CW), .AW(AW), .LW(LW)) u_xcorr (
    .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_re(loc_re),
    .loc_im(loc_im), .prv_valid(prv_valid), .prv_re(prv_re), .prv_im(prv_im),
    .int_len(int_len), .ack_evt(ack_evt), .dump_re(dump_re),
    .dump_im(dump_im), .act_re(act_re), .act_im(act_im),
    .dump_ready(dump_ready), .swap_evt(swap_evt)
  );

  // one-register pass-through of the upstream channelized stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_valid <= 1'b0;
      nxt_re    <= '0;
      nxt_im    <= '0;
    end else begin
      nxt_valid <= prv_valid;
      nxt_re    <= prv_re;
      nxt_im    <= prv_im;
    end
  end
endmodule

// File: rtl/bf_ring_node_chk.sv
module bf_ring_node_chk #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 bin_valid,
  input logic                 bout_valid,
  input logic                 tap_valid,
  input logic                 prv_valid,
  input logic signed [CW-1:0] prv_re,
  input logic signed [CW-1:0] prv_im,
  input logic                 nxt_valid,
  input logic signed [CW-1:0] nxt_re,
  input logic signed [CW-1:0] nxt_im,
  input logic                 swap_evt,
  input logic                 ack_evt,
  input logic                 dump_ready,
  input logic signed [AW-1:0] act_re,
  input logic signed [AW-1:0] act_im
);
  p_bout_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bin_valid) |=> bout_valid);

  p_bout_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && bin_valid) |=> !bout_valid);

  p_tap_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid == bout_valid);

  p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nxt_valid == $past(prv_valid) && nxt_re == $past(prv_re)
              && nxt_im == $past(prv_im)));

  p_swap_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> dump_ready);

  p_swap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (act_re == '0 && act_im == '0));

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_ready && !ack_evt) |=> dump_ready);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !swap_evt) |=> !dump_ready);

  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_ready) |-> $past(swap_evt));
endmodule

bind bf_ring_node bf_ring_node_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .bin_valid(bin_valid),
  .bout_valid(bout_valid), .tap_valid(tap_valid), .prv_valid(prv_valid),
  .prv_re(prv_re), .prv_im(prv_im), .nxt_valid(nxt_valid), .nxt_re(nxt_re),
  .nxt_im(nxt_im), .swap_evt(swap_evt), .ack_evt(ack_evt),
  .dump_ready(dump_ready), .act_re(act_re), .act_im(act_im)
);

// File: tb/tb_bf_ring_node.sv
module tb_bf_ring_node;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 4, SW = 8, WW = 12, BW = 24, CW = 16, AW = 32, RAW = 4;
  localparam int NCYC = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 0, bin_valid = 0, loc_valid = 0, prv_valid = 0, reg_we = 0;
  logic [NIN*SW-1:0] smp_re = '0, smp_im = '0;
  logic signed [BW-1:0] bin_re = '0, bin_im = '0;
  logic signed [CW-1:0] loc_re = '0, loc_im = '0, prv_re = '0, prv_im = '0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic bout_valid, tap_valid, nxt_valid;
  logic signed [BW-1:0] bout_re, bout_im, tap_re, tap_im;
  logic signed [CW-1:0] nxt_re, nxt_im;
  logic [31:0] reg_rdata;

  bf_ring_node dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  longint m_wre[NIN], m_wim[NIN], m_len, m_cnt, m_acc_re, m_acc_im, m_dre, m_dim;
  int m_sel;
  bit m_rdy;
  // expected outputs
  longint e_bv, e_bre, e_bim, e_tv, e_tre, e_tim, e_nv, e_nre, e_nim;
  logic [31:0] e_rd;
  string tag_b, tag_rd;

  function automatic longint clip(input longint v, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint sx(input longint v, input int w);
    longint m = longint'(1) <<< w;
    v = v & (m - 1);
    return (v >= (m >>> 1)) ? v - m : v;
  endfunction

  function automatic longint rnd_s(input int w, input bit ext);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (ext) return ($urandom_range(0, 1) != 0) ? hi : -hi - 1;
    return longint'($urandom_range(0, (1 << w) - 1)) - hi - 1;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 beam valid", longint'(bout_valid), e_bv);
    chk({tag_b, " real"}, longint'(bout_re), e_bre);
    chk({tag_b, " imag"}, longint'(bout_im), e_bim);
    chk("R2 tap valid", longint'(tap_valid), e_tv);
    chk("R2 tap real", longint'(tap_re), e_tre);
    chk("R2 tap imag", longint'(tap_im), e_tim);
    chk("R9 forward valid", longint'(nxt_valid), e_nv);
    chk("R9 forward real", longint'(nxt_re), e_nre);
    chk("R9 forward imag", longint'(nxt_im), e_nim);
    chk(tag_rd, longint'(reg_rdata), longint'(e_rd));
  endtask

  function automatic logic [31:0] model_read(input int a);
    if (a < NIN) return {8'd0, 12'(m_wim[a]), 12'(m_wre[a])};
    if (a == 4) return 32'(m_sel);
    if (a == 5) return 32'(m_len);
    if (a == 6) return 32'(m_dre);
    if (a == 7) return 32'(m_dim);
    if (a == 8) return {31'd0, m_rdy};
    return 32'd0;
  endfunction

  // advance the reference model by one clock using the values just driven
  task automatic model_step();
    longint xr[NIN], xi[NIN], tr[NIN], ti[NIN];
    longint sr, si, pr, pi, nr, ni, eff;
    bit swapped = 0;
    for (int k = 0; k < NIN; k++) begin
      xr[k] = sx(longint'(smp_re[k*SW +: SW]), SW);
      xi[k] = sx(longint'(smp_im[k*SW +: SW]), SW);
    end
    if (smp_valid && bin_valid) begin
      sr = longint'(bin_re);
      si = longint'(bin_im);
      for (int k = 0; k < NIN; k++) begin
        tr[k] = xr[k] * m_wre[k] - xi[k] * m_wim[k];
        ti[k] = xr[k] * m_wim[k] + xi[k] * m_wre[k];
        sr += tr[k];
        si += ti[k];
      end
      e_bv = 1; e_tv = 1;
      e_bre = clip(sr, BW);
      e_bim = clip(si, BW);
      tag_b = (e_bre != sr || e_bim != si) ? "R4 saturated beam" : "R1 beam";
      if (m_sel < NIN) begin
        e_tre = clip(tr[m_sel], BW);
        e_tim = clip(ti[m_sel], BW);
      end else begin
        e_tre = e_bre;
        e_tim = e_bim;
      end
    end else begin
      e_bv = 0; e_tv = 0;
    end
    e_nv = longint'(prv_valid);
    e_nre = longint'(prv_re);
    e_nim = longint'(prv_im);
    if (loc_valid && prv_valid) begin
      pr = longint'(loc_re) * longint'(prv_re) + longint'(loc_im) * longint'(prv_im);
      pi = longint'(loc_im) * longint'(prv_re) - longint'(loc_re) * longint'(prv_im);
      nr = clip(m_acc_re + pr, AW);
      ni = clip(m_acc_im + pi, AW);
      eff = (m_len == 0) ? 1 : m_len;
      if (m_cnt + 1 >= eff) begin
        m_dre = nr; m_dim = ni; m_acc_re = 0; m_acc_im = 0; m_cnt = 0; swapped = 1;
      end else begin
        m_acc_re = nr; m_acc_im = ni; m_cnt++;
      end
    end
    if (swapped) m_rdy = 1;
    else if (reg_we && reg_addr == 4'd8 && reg_wdata[0]) m_rdy = 0;
    if (reg_we) begin
      if (int'(reg_addr) < NIN) begin
        m_wre[reg_addr] = sx(longint'(reg_wdata[11:0]), 12);
        m_wim[reg_addr] = sx(longint'(reg_wdata[23:12]), 12);
      end else if (reg_addr == 4'd4) m_sel = int'(reg_wdata[2:0]);
      else if (reg_addr == 4'd5) m_len = longint'(reg_wdata);
    end
    e_rd = model_read(int'(reg_addr));
    if (int'(reg_addr) < 4) tag_rd = "R3 weight readback";
    else if (reg_addr == 4'd4 || reg_addr == 4'd5) tag_rd = "R3 config readback";
    else if (reg_addr == 4'd6 || reg_addr == 4'd7) tag_rd = "R5 R6 R7 dump readback";
    else tag_rd = "R8 status readback";
  endtask

  task automatic drive(input int cyc);
    bit ext = (cyc >= 1800 && cyc < 2300);
    int lens[5] = '{3, 1, 0, 6, 2};
    int rot[6] = '{6, 7, 8, 4, 5, 0};
    smp_valid = ($urandom_range(0, 3) != 0);
    bin_valid = ($urandom_range(0, 4) != 0);
    loc_valid = ($urandom_range(0, 3) != 0);
    prv_valid = ($urandom_range(0, 3) != 0);
    for (int k = 0; k < NIN; k++) begin
      smp_re[k*SW +: SW] = SW'(rnd_s(SW, ext));
      smp_im[k*SW +: SW] = SW'(rnd_s(SW, ext));
    end
    bin_re = ext ? BW'(rnd_s(BW, 1)) : BW'(rnd_s(21, 0));
    bin_im = ext ? BW'(rnd_s(BW, 1)) : BW'(rnd_s(21, 0));
    loc_re = CW'(rnd_s(CW, ext)); loc_im = CW'(rnd_s(CW, ext));
    prv_re = CW'(rnd_s(CW, ext)); prv_im = CW'(rnd_s(CW, ext));
    reg_we = 1'b1;
    if (cyc < NIN || (cyc >= 1800 && cyc < 1800 + NIN)) begin
      reg_addr = RAW'(cyc % NIN);
      reg_wdata = {8'd0, 12'(rnd_s(WW, ext)), 12'(rnd_s(WW, ext))};
    end else if (cyc % 200 == 5) begin
      reg_addr = 4'd5; reg_wdata = 32'(lens[(cyc / 200) % 5]);
    end else if (cyc % 50 == 7) begin
      reg_addr = 4'd4; reg_wdata = 32'((cyc / 50) % 6);
    end else if (cyc % 41 == 9) begin
      reg_addr = 4'd8; reg_wdata = 32'd1;
    end else if (cyc % 300 == 11) begin
      reg_addr = RAW'((cyc / 300) % NIN);
      reg_wdata = {8'd0, 12'(rnd_s(WW, 0)), 12'(rnd_s(WW, 0))};
    end else begin
      reg_we = 1'b0;
      reg_addr = RAW'(rot[cyc % 6]);
      reg_wdata = $urandom();
    end
  endtask

  initial begin
    for (int k = 0; k < NIN; k++) begin m_wre[k] = 0; m_wim[k] = 0; end
    m_sel = 0; m_len = 4; m_cnt = 0; m_rdy = 0;
    m_acc_re = 0; m_acc_im = 0; m_dre = 0; m_dim = 0;
    repeat (3) @(negedge clk);
    // R10: reset state seen at the ports while reset is held
    chk("R10 reset beam valid", longint'(bout_valid), 0);
    chk("R10 reset tap valid", longint'(tap_valid), 0);
    chk("R10 reset forward valid", longint'(nxt_valid), 0);
    chk("R10 reset beam data", longint'(bout_re), 0);
    reg_addr = 4'd8; #1;
    chk("R10 reset ready flag", longint'(reg_rdata), 0);
    reg_addr = 4'd6; #1;
    chk("R10 reset dump", longint'(reg_rdata), 0);
    reg_addr = 4'd5; #1;
    chk("R3 reset length", longint'(reg_rdata), 4);
    rst_n = 1'b1;
    e_bv = 0; e_bre = 0; e_bim = 0; e_tv = 0; e_tre = 0; e_tim = 0;
    e_nv = 0; e_nre = 0; e_nim = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      drive(cyc);
      model_step();
      @(negedge clk);
      compare_all();
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule